// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column address of a memory burst, one address per clock. A command decoder upstream pulses `start` together with a start column and the burst mode: a length code, an order bit (linear or XOR-interleaved), a read/write bit and a write-single override bit. From the next clock on, the block presents one column per enabled clock edge. It marks the final beat of a finite burst and drops `col_valid` once the burst is over.

Every beat stays inside the aligned window of the burst length. The column bits above that window keep the start column's value, so the address wraps inside the window and never carries upward. A page-length burst covers every column and runs until `stop` or a new `start` ends it. While `cke` is low, the walk and all outputs hold, and `start` and `stop` are ignored. Reserved length codes run as single-beat bursts and set a sticky error flag that only reset clears.

Top module: `burst_col_gen`

## Requirements
- R1: A synchronous reset drives `col_valid`, `last_beat` and `rsv_err` low and `col_addr` to zero.
- R2: Length codes map to beat counts as 000→1, 001→2, 010→4, 011→8 and 111→page (2^COL_W beats). `col_valid` is high for exactly that many enabled cycles of a finite burst and then goes low.
- R3: With `interleave`=0 the beat address is the start column plus the beat index, taken modulo the window length. Example: start 2, length 4 gives 2,3,0,1.
- R4: With `interleave`=1 the beat address is the start column XOR the beat index, inside the window. Example: start 5, length 8 gives 5,4,7,6,1,0,3,2.
- R5: The column bits above the burst window equal those of the start column on every beat.
- R6: Code 111 steps linearly through all columns and wraps from the top column to 0. The `interleave` bit has no effect in this mode. The burst continues until it is stopped.
- R7: `last_beat` is high on the final beat of a finite burst only. It is never high in page mode.
- R8: When both `is_write` and `wr_single` are 1, the burst has one beat. A read with `wr_single`=1 uses the programmed length.
- R9: If `stop` is sampled high during a burst, `col_valid` is low from the next cycle. If `stop` arrives while the block is idle, `col_addr` and `col_valid` do not change.
- R10: A `start` sampled during a burst abandons that burst. The next cycle shows beat 0 of the new burst with the new parameters. `start` takes priority over `stop`.
- R11: While `cke` is low, `col_addr`, `col_valid`, `last_beat` and the beat position hold, and `start` and `stop` are ignored.
- R12: Reserved codes 100, 101 and 110 produce a one-beat burst and set `rsv_err`. `rsv_err` stays high until reset.
- R13: Beat 0 (the start column) appears on the cycle after the edge that samples `start`. Each later enabled edge advances one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the generator |
| start | input | 1 | Burst command pulse |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 0 linear order, 1 XOR order |
| is_write | input | 1 | Burst is a write |
| wr_single | input | 1 | Force write bursts to one beat |
| stop | input | 1 | Terminate the running burst |
| col_addr | output | COL_W | Current beat column |
| col_valid | output | 1 | A burst beat is presented |
| last_beat | output | 1 | Final beat of a finite burst |
| rsv_err | output | 1 | Sticky reserved-code error |

## Verification
The embedded assertions check the rules that hold on every cycle. Outputs hold while `cke` is low. `last_beat` appears only with `col_valid` and never in page mode. The bits above the window match the base column. A stop or a final beat ends the burst on the next cycle. The error flag never clears without reset. The exact address orders depend on the start column and the mode, so only the bench's directed scenarios can show them. The same holds for the beat counts per length code, the write-single override, the restart on a new command and the page-mode wrap past the top column.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam logic [2:0] LC_ONE  = 3'b000;
  localparam logic [2:0] LC_TWO  = 3'b001;
  localparam logic [2:0] LC_FOUR = 3'b010;
  localparam logic [2:0] LC_OCT  = 3'b011;
  localparam logic [2:0] LC_PAGE = 3'b111;
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             wr_single,
  output logic [COL_W-1:0] win_mask,
  output logic             full_page,
  output logic             inter_eff,
  output logic             reserved
);
  import burst_pkg::*;
  localparam int SH_W = $clog2(COL_W + 1);

  logic [SH_W-1:0] sh;
  logic [COL_W:0]  span;

  always_comb begin
    reserved  = 1'b0;
    full_page = 1'b0;
    unique case (len_code)
      LC_ONE:  sh = SH_W'(0);
      LC_TWO:  sh = SH_W'(1);
      LC_FOUR: sh = SH_W'(2);
      LC_OCT:  sh = SH_W'(3);
      LC_PAGE: begin sh = SH_W'(COL_W); full_page = 1'b1; end
      default: begin sh = SH_W'(0); reserved = 1'b1; end
    endcase
    if (is_write && wr_single) begin
      sh        = SH_W'(0);
      full_page = 1'b0;
    end
    span      = ({{COL_W{1'b0}}, 1'b1} << sh) - 1'b1;
    win_mask  = span[COL_W-1:0];
    inter_eff = interleave && !full_page;
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] win_mask,
  input  logic             inter,
  input  logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] low;

  always_comb begin
    low  = inter ? (base ^ idx) : (base + idx);
    addr = (base & ~win_mask) | (low & win_mask);
  end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] dec_mask,
  input  logic             dec_full,
  input  logic             dec_inter,
  input  logic             dec_rsv,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic             inter_q,
  output logic [COL_W-1:0] idx_nxt,
  input  logic [COL_W-1:0] addr_nxt,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             last_beat,
  output logic             rsv_err
);
  logic [COL_W-1:0] idx_q;
  logic             full_q;

  assign idx_nxt = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      mask_q    <= '0;
      inter_q   <= 1'b0;
      full_q    <= 1'b0;
      idx_q     <= '0;
      col_addr  <= '0;
      col_valid <= 1'b0;
      last_beat <= 1'b0;
      rsv_err   <= 1'b0;
    end else if (cke) begin
      if (start) begin
        base_q    <= start_col;
        mask_q    <= dec_mask;
        inter_q   <= dec_inter;
        full_q    <= dec_full;
        idx_q     <= '0;
        col_addr  <= start_col;
        col_valid <= 1'b1;
        last_beat <= !dec_full && (dec_mask == '0);
        rsv_err   <= rsv_err | dec_rsv;
      end else if (col_valid) begin
        if (stop || last_beat) begin
          col_valid <= 1'b0;
          last_beat <= 1'b0;
        end else begin
          idx_q     <= idx_nxt;
          col_addr  <= addr_nxt;
          last_beat <= !full_q && (idx_nxt == mask_q);
        end
      end
    end
  end

  // R11
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(col_addr) && $stable(col_valid) && $stable(last_beat)));
  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> col_valid);
  // R7
  page_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (full_q && col_valid) |-> !last_beat);
  // R5
  upper_bits_chk: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> (((col_addr ^ base_q) & ~mask_q) == '0));
  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (cke && stop && !start && col_valid) |=> !col_valid);
  // R2
  last_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (cke && last_beat && !start) |=> !col_valid);
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rsv_err |=> rsv_err);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             wr_single,
  input  logic             stop,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             last_beat,
  output logic             rsv_err
);
  logic [COL_W-1:0] dec_mask, base_q, mask_q, idx_nxt, addr_nxt;
  logic             dec_full, dec_inter, dec_rsv, inter_q;

  burst_mode_decode #(.COL_W(COL_W)) dec_i (
    .len_code(len_code), .interleave(interleave), .is_write(is_write),
    .wr_single(wr_single), .win_mask(dec_mask), .full_page(dec_full),
    .inter_eff(dec_inter), .reserved(dec_rsv)
  );

  burst_addr_calc #(.COL_W(COL_W)) calc_i (
    .base(base_q), .win_mask(mask_q), .inter(inter_q), .idx(idx_nxt),
    .addr(addr_nxt)
  );

  burst_beat_seq #(.COL_W(COL_W)) seq_i (
    .clk(clk), .rst(rst), .cke(cke), .start(start), .stop(stop),
    .start_col(start_col), .dec_mask(dec_mask), .dec_full(dec_full),
    .dec_inter(dec_inter), .dec_rsv(dec_rsv), .base_q(base_q),
    .mask_q(mask_q), .inter_q(inter_q), .idx_nxt(idx_nxt),
    .addr_nxt(addr_nxt), .col_addr(col_addr), .col_valid(col_valid),
    .last_beat(last_beat), .rsv_err(rsv_err)
  );
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1, start = 1'b0, interleave = 1'b0;
  logic       is_write = 1'b0, wr_single = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic [7:0] col_addr;
  logic       col_valid, last_beat, rsv_err;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(8)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .is_write(is_write),
    .wr_single(wr_single), .stop(stop), .col_addr(col_addr),
    .col_valid(col_valid), .last_beat(last_beat), .rsv_err(rsv_err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(logic [7:0] b, int len, logic inter, int i);
    logic [7:0] m  = 8'(len - 1);
    logic [7:0] iv = 8'(i);
    if (inter && len != 256) return (b & ~m) | ((b ^ iv) & m);
    return (b & ~m) | ((b + iv) & m);
  endfunction

  task automatic issue(logic [7:0] col, logic [2:0] code, logic inter, logic wr, logic ws);
    @(negedge clk);
    start = 1'b1; start_col = col; len_code = code;
    interleave = inter; is_write = wr; wr_single = ws;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_beats(string req, logic [7:0] b, int len, logic inter, int first, int cnt);
    for (int k = 0; k < cnt; k++) begin
      chk({req, " addr"}, col_addr, exp_addr(b, len, inter, first + k));
      chk({req, " valid"}, col_valid, 1);
      chk("R7 last", last_beat, (len != 256 && first + k == len - 1) ? 1 : 0);
      if (k < cnt - 1) @(negedge clk);
    end
  endtask

  task automatic expect_idle(string req);
    @(negedge clk);
    chk({req, " idle"}, col_valid, 0);
    chk({req, " idle last"}, last_beat, 0);
  endtask

  task automatic t_reset();
    chk("R1 addr", col_addr, 0);
    chk("R1 valid", col_valid, 0);
    chk("R1 last", last_beat, 0);
    chk("R1 err", rsv_err, 0);
  endtask

  task automatic t_lengths();
    issue(8'h30, 3'b000, 0, 0, 0); expect_beats("R2 len1", 8'h30, 1, 0, 0, 1); expect_idle("R2");
    issue(8'h31, 3'b001, 0, 0, 0); expect_beats("R2 len2", 8'h31, 2, 0, 0, 2); expect_idle("R2");
    issue(8'h02, 3'b010, 0, 0, 0); expect_beats("R3 s2l4", 8'h02, 4, 0, 0, 4); expect_idle("R3");
    issue(8'h46, 3'b011, 0, 0, 0); expect_beats("R5 upper", 8'h46, 8, 0, 0, 8); expect_idle("R2");
    chk("R12 no err yet", rsv_err, 0);
  endtask

  task automatic t_interleave();
    issue(8'h05, 3'b011, 1, 0, 0); expect_beats("R4 s5l8", 8'h05, 8, 1, 0, 8); expect_idle("R4");
    issue(8'hB6, 3'b010, 1, 0, 0); expect_beats("R4 upper", 8'hB6, 4, 1, 0, 4); expect_idle("R4");
  endtask

  task automatic t_write_single();
    issue(8'h1B, 3'b011, 0, 1, 1); expect_beats("R8 wr", 8'h1B, 1, 0, 0, 1); expect_idle("R8");
    issue(8'h1B, 3'b011, 0, 0, 1); expect_beats("R8 rd", 8'h1B, 8, 0, 0, 8); expect_idle("R8");
  endtask

  task automatic t_page();
    issue(8'hFA, 3'b111, 1, 0, 0);
    expect_beats("R6 page", 8'hFA, 256, 0, 0, 12);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R9 page stop", col_valid, 0);
  endtask

  task automatic t_stop();
    logic [7:0] held;
    issue(8'h60, 3'b011, 0, 0, 0);
    expect_beats("R9 pre", 8'h60, 8, 0, 0, 3);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R9 stop", col_valid, 0);
    held = col_addr;
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    @(negedge clk);
    chk("R9 idle stop valid", col_valid, 0);
    chk("R9 idle stop addr", col_addr, held);
  endtask

  task automatic t_restart();
    issue(8'h10, 3'b011, 0, 0, 0);
    expect_beats("R10 pre", 8'h10, 8, 0, 0, 4);
    start = 1'b1; stop = 1'b1; start_col = 8'h25; len_code = 3'b010; interleave = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    expect_beats("R10 new", 8'h25, 4, 1, 0, 4); expect_idle("R10");
  endtask

  task automatic t_freeze();
    issue(8'h80, 3'b011, 0, 0, 0);
    expect_beats("R13 timing", 8'h80, 8, 0, 0, 3);
    cke = 1'b0; stop = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 addr", col_addr, 8'h82);
      chk("R11 valid", col_valid, 1);
    end
    stop = 1'b0; start = 1'b1; start_col = 8'h44;
    @(negedge clk);
    chk("R11 start ignored", col_addr, 8'h82);
    start = 1'b0; cke = 1'b1;
    @(negedge clk);
    expect_beats("R11 resume", 8'h80, 8, 0, 3, 5); expect_idle("R11");
  endtask

  task automatic t_reserved();
    issue(8'h77, 3'b101, 0, 0, 0);
    expect_beats("R12 rsv", 8'h77, 1, 0, 0, 1);
    chk("R12 err set", rsv_err, 1);
    expect_idle("R12");
    issue(8'h20, 3'b010, 0, 0, 0); expect_beats("R12 after", 8'h20, 4, 0, 0, 4);
    chk("R12 sticky", rsv_err, 1);
    expect_idle("R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_interleave();
    t_write_single();
    t_page();
    t_stop();
    t_restart();
    t_freeze();
    t_reserved();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule